// File: doc/BRIEF.md
# Interrupt Steering and Latch Block

This block sits on the peripheral-bus side of a host controller and takes a 16-bit vector of active interrupt requests. In routed operation each request carries a 2-bit selector that steers it onto one of four output lines; the outputs are a combinational OR of the requests steered to them. In legacy operation the steering is bypassed: all requests are ORed into one summary bit, that bit is gated by a mask and collected in a sticky status register, and a single line stays high while any status bit is set.

Software programs the block through a 32-bit register port with separate read and write strobes. Read data is registered and appears one cycle after the read strobe. A static mode pin selects legacy or routed operation. A polarity register is kept for software but does not change any output.

Top module: `irq_steer_top`

## Requirements
- R1: After reset the steer registers, status and mask read as zero, the latched line is low, and in routed mode every active request drives output 0.
- R2: Registers sit at byte offsets 0x08 (steer A), 0x0C (steer B), 0x50 (status), 0x54 (mask), 0x58 (polarity) and 0x5C (input); read data appears on rdData one cycle after rdEn, and steer A, steer B, mask and polarity read back the last value written.
- R3: A read of any offset outside that set returns 0xFFFFFFFF.
- R4: For request n from 0 to 13 the selector is bits [27-2n : 26-2n] of steer B (bit 0 being the LSB), so request 0 uses bits 27:26 and request 13 uses bits 1:0.
- R5: For request 14 and 15 the selector is bits [23-2k : 22-2k] of steer A with k = n-14, so request 14 uses bits 23:22 and request 15 uses bits 21:20.
- R6: In routed mode routedIrq[o] is high in the same cycle as reqIn whenever some active request has selector value o; a steer write changes the steering from the next cycle on.
- R7: In routed mode the input register reads zero and the latched line never rises.
- R8: In legacy mode routedIrq is all zero and steer writes are stored but do not load the steering table, so the steering in force before the write is still in force if the mode pin later selects routed operation.
- R9: In legacy mode input register bit 11 (value 0x800) reads 1 exactly when any bit of reqIn is high; all its other bits read 0.
- R10: In legacy mode each cycle ORs (input value AND mask) into status; status bits stay set after the requests drop, and latchedIrq is high exactly when status is nonzero, one cycle after the request that sets it.
- R11: A status write clears every bit where the written data has a 1, except a bit whose masked input is still active in that cycle, which stays set.
- R12: Writes to the input register are dropped, and the polarity value has no effect on routedIrq or latchedIrq.
- R13: A mask write takes effect in the same cycle: a request active during the mask write is latched at that same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| legacyMode | input | 1 | 1 selects single latched line, 0 selects four routed lines |
| reqIn | input | 16 | Active interrupt requests, bit n is request n |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 8 | Register byte offset |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data, valid one cycle after rdEn |
| routedIrq | output | 4 | Routed interrupt lines |
| latchedIrq | output | 1 | Legacy latched interrupt line |

## Verification
The routed lines are combinational from reqIn but a steer write only shows on them after the next edge, so the bench checks routedIrq in the cycle the request is applied and after each steer write. Status, the latched line and read data each come from one register stage, so they are due one edge after the write, read or request that causes them. The bench drives every input on the falling edge, lets its behavioural model step on the rising edge, and compares all outputs at the following falling edge, when both have settled.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;

  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 8;
  localparam int NUM_REQ = 16;
  localparam int NUM_OUT = 4;
  localparam int SEL_W   = 2;

  // Register byte offsets (decoded by software drivers, so they stay fixed)
  localparam int OFS_STEER_A = 'h08;
  localparam int OFS_STEER_B = 'h0C;
  localparam int OFS_STAT    = 'h50;
  localparam int OFS_MASK    = 'h54;
  localparam int OFS_POL     = 'h58;
  localparam int OFS_INPUT   = 'h5C;

  // Selector layout: requests below SPLIT_REQ live in steer B, the rest in steer A
  localparam int SPLIT_REQ  = 14;
  localparam int B_TOP_BIT  = 27;
  localparam int A_TOP_BIT  = 23;
  localparam int SUMMARY_BIT = 11;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_STEER_A,
    RD_STEER_B,
    RD_STAT,
    RD_MASK,
    RD_POL,
    RD_INPUT,
    RD_UNMAPPED
  } rdSel_e;

  typedef struct packed {
    logic   wrSteerA;
    logic   wrSteerB;
    logic   wrStat;
    logic   wrMask;
    logic   wrPol;
    rdSel_e rdSel;
  } strobes_t;

endpackage

// File: rtl/irq_steer_ctrl.sv
module irq_steer_ctrl
  import irq_steer_pkg::*;
#(
  parameter int ADDR_WIDTH = ADDR_W
) (
  input  logic                  wrEn,
  input  logic                  rdEn,
  input  logic [ADDR_WIDTH-1:0] addr,
  output strobes_t              strb
);

  rdSel_e target;

  always_comb begin
    strb   = '0;
    target = RD_UNMAPPED;
    case (addr)
      ADDR_WIDTH'(OFS_STEER_A): begin strb.wrSteerA = wrEn; target = RD_STEER_A; end
      ADDR_WIDTH'(OFS_STEER_B): begin strb.wrSteerB = wrEn; target = RD_STEER_B; end
      ADDR_WIDTH'(OFS_STAT):    begin strb.wrStat   = wrEn; target = RD_STAT;    end
      ADDR_WIDTH'(OFS_MASK):    begin strb.wrMask   = wrEn; target = RD_MASK;    end
      ADDR_WIDTH'(OFS_POL):     begin strb.wrPol    = wrEn; target = RD_POL;     end
      ADDR_WIDTH'(OFS_INPUT):   begin target = RD_INPUT; end  // read-only, write dropped
      default:                  target = RD_UNMAPPED;
    endcase
    strb.rdSel = rdEn ? target : RD_NONE;
  end

endmodule

// File: rtl/irq_steer_dp.sv
module irq_steer_dp
  import irq_steer_pkg::*;
#(
  parameter int DATA_WIDTH = DATA_W,
  parameter int REQ_COUNT  = NUM_REQ,
  parameter int OUT_COUNT  = NUM_OUT
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  legacyMode,
  input  logic [REQ_COUNT-1:0]  reqIn,
  input  logic [DATA_WIDTH-1:0] wrData,
  input  strobes_t              strb,
  output logic [DATA_WIDTH-1:0] rdData,
  output logic [OUT_COUNT-1:0]  routedIrq,
  output logic                  latchedIrq
);

  logic [DATA_WIDTH-1:0] steerAQ, steerBQ, statQ, maskQ, polQ;
  logic [DATA_WIDTH-1:0] steerANx, steerBNx, maskNx, clrVec, inVec, statNx, readMux;
  logic [SEL_W-1:0]      selQ    [REQ_COUNT];
  logic [SEL_W-1:0]      selNext [REQ_COUNT];
  logic                  loadTable;

  assign steerANx  = strb.wrSteerA ? wrData : steerAQ;
  assign steerBNx  = strb.wrSteerB ? wrData : steerBQ;
  assign maskNx    = strb.wrMask   ? wrData : maskQ;
  assign clrVec    = strb.wrStat   ? wrData : '0;
  assign loadTable = (strb.wrSteerA || strb.wrSteerB) && !legacyMode;

  // Selector extraction: positions step down two bits per request
  for (genvar n = 0; n < REQ_COUNT; n++) begin : g_sel
    if (n < SPLIT_REQ) begin : g_lo
      assign selNext[n] = steerBNx[B_TOP_BIT - 2*n -: SEL_W];
    end else begin : g_hi
      assign selNext[n] = steerANx[A_TOP_BIT - 2*(n - SPLIT_REQ) -: SEL_W];
    end
  end

  always_comb begin
    inVec = '0;
    inVec[SUMMARY_BIT] = legacyMode && (|reqIn);
  end

  // Clear first, then re-apply whatever is still asserting
  assign statNx = (statQ & ~clrVec) | (inVec & maskNx);

  always_comb begin
    case (strb.rdSel)
      RD_STEER_A: readMux = steerAQ;
      RD_STEER_B: readMux = steerBQ;
      RD_STAT:    readMux = statQ;
      RD_MASK:    readMux = maskQ;
      RD_POL:     readMux = polQ;
      RD_INPUT:   readMux = inVec;
      default:    readMux = '1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      steerAQ <= '0;
      steerBQ <= '0;
      statQ   <= '0;
      maskQ   <= '0;
      polQ    <= '0;
      rdData  <= '0;
      for (int n = 0; n < REQ_COUNT; n++) selQ[n] <= '0;
    end else begin
      steerAQ <= steerANx;
      steerBQ <= steerBNx;
      maskQ   <= maskNx;
      statQ   <= statNx;
      if (strb.wrPol) polQ <= wrData;
      if (loadTable) begin
        for (int n = 0; n < REQ_COUNT; n++) selQ[n] <= selNext[n];
      end
      if (strb.rdSel != RD_NONE) rdData <= readMux;
    end
  end

  always_comb begin
    routedIrq = '0;
    if (!legacyMode) begin
      for (int n = 0; n < REQ_COUNT; n++) begin
        if (reqIn[n]) routedIrq[selQ[n]] = 1'b1;
      end
    end
  end

  assign latchedIrq = |statQ;

endmodule

// File: rtl/irq_steer_top.sv
module irq_steer_top
  import irq_steer_pkg::*;
#(
  parameter int ADDR_WIDTH = ADDR_W,
  parameter int DATA_WIDTH = DATA_W,
  parameter int REQ_COUNT  = NUM_REQ,
  parameter int OUT_COUNT  = NUM_OUT
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  legacyMode,
  input  logic [REQ_COUNT-1:0]  reqIn,
  input  logic                  wrEn,
  input  logic                  rdEn,
  input  logic [ADDR_WIDTH-1:0] addr,
  input  logic [DATA_WIDTH-1:0] wrData,
  output logic [DATA_WIDTH-1:0] rdData,
  output logic [OUT_COUNT-1:0]  routedIrq,
  output logic                  latchedIrq
);

  strobes_t strb;

  irq_steer_ctrl #(.ADDR_WIDTH(ADDR_WIDTH)) u_ctrl (
    .wrEn (wrEn),
    .rdEn (rdEn),
    .addr (addr),
    .strb (strb)
  );

  irq_steer_dp #(
    .DATA_WIDTH (DATA_WIDTH),
    .REQ_COUNT  (REQ_COUNT),
    .OUT_COUNT  (OUT_COUNT)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .legacyMode (legacyMode),
    .reqIn      (reqIn),
    .wrData     (wrData),
    .strb       (strb),
    .rdData     (rdData),
    .routedIrq  (routedIrq),
    .latchedIrq (latchedIrq)
  );

endmodule

// File: rtl/irq_steer_chk.sv
module irq_steer_chk
  import irq_steer_pkg::*;
#(
  parameter int ADDR_WIDTH = ADDR_W,
  parameter int DATA_WIDTH = DATA_W,
  parameter int REQ_COUNT  = NUM_REQ,
  parameter int OUT_COUNT  = NUM_OUT
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  legacyMode,
  input logic [REQ_COUNT-1:0]  reqIn,
  input logic                  wrEn,
  input logic                  rdEn,
  input logic [ADDR_WIDTH-1:0] addr,
  input logic [DATA_WIDTH-1:0] wrData,
  input logic [DATA_WIDTH-1:0] rdData,
  input logic [OUT_COUNT-1:0]  routedIrq,
  input logic                  latchedIrq
);

  logic mapped, statWr;

  assign mapped = (addr == ADDR_WIDTH'(OFS_STEER_A)) || (addr == ADDR_WIDTH'(OFS_STEER_B)) ||
                  (addr == ADDR_WIDTH'(OFS_STAT))    || (addr == ADDR_WIDTH'(OFS_MASK))    ||
                  (addr == ADDR_WIDTH'(OFS_POL))     || (addr == ADDR_WIDTH'(OFS_INPUT));
  assign statWr = wrEn && (addr == ADDR_WIDTH'(OFS_STAT));

  // R3
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !mapped) |=> (rdData == '1));

  // R6
  idle_routes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!legacyMode && reqIn == '0) |-> (routedIrq == '0));

  // R7
  routed_no_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!legacyMode && !latchedIrq) |=> !latchedIrq);

  // R10
  latch_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (latchedIrq && !statWr) |=> latchedIrq);

  // R11
  full_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statWr && wrData == '1 && reqIn == '0) |=> !latchedIrq);

endmodule

bind irq_steer_top irq_steer_chk #(
  .ADDR_WIDTH (ADDR_WIDTH),
  .DATA_WIDTH (DATA_WIDTH),
  .REQ_COUNT  (REQ_COUNT),
  .OUT_COUNT  (OUT_COUNT)
) u_chk (.*);

// File: tb/sim_irq_steer_top.sv
`timescale 1ns/1ps
module sim_irq_steer_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        legacyMode = 1'b0;
  logic [15:0] reqIn = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [3:0]  routedIrq;
  logic        latchedIrq;

  int nChk = 0;
  int nFail = 0;
  string rdTag = "R2";

  always #2 clk = ~clk;

  irq_steer_top u0 (
    .clk(clk), .rstN(rstN), .legacyMode(legacyMode), .reqIn(reqIn),
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .routedIrq(routedIrq), .latchedIrq(latchedIrq)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0] mA, mB, mStat, mMask, mPol, mRd;
  int          mSel [16];
  logic        mRdValid;

  function automatic logic [31:0] inputWord();
    return (legacyMode && reqIn != 0) ? 32'h800 : 32'h0;
  endfunction

  function automatic logic [31:0] modelRead(int a);
    case (a)
      'h08: return mA;
      'h0C: return mB;
      'h50: return mStat;
      'h54: return mMask;
      'h58: return mPol;
      'h5C: return inputWord();
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [3:0] modelRoutes();
    logic [3:0] r = '0;
    if (!legacyMode)
      for (int n = 0; n < 16; n++) if (reqIn[n]) r[mSel[n]] = 1'b1;
    return r;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mA = 0; mB = 0; mStat = 0; mMask = 0; mPol = 0; mRd = 0; mRdValid = 0;
      for (int n = 0; n < 16; n++) mSel[n] = 0;
    end else begin
      logic [31:0] inW, clr;
      inW = inputWord();
      mRdValid = rdEn;
      if (rdEn) mRd = modelRead(addr);
      clr = 0;
      if (wrEn) begin
        case (addr)
          'h08: mA = wrData;
          'h0C: mB = wrData;
          'h50: clr = wrData;
          'h54: mMask = wrData;
          'h58: mPol = wrData;
          default: ;
        endcase
        if ((addr == 'h08 || addr == 'h0C) && !legacyMode) begin
          for (int n = 0; n < 14; n++) mSel[n] = int'((mB >> (26 - 2*n)) & 32'h3);
          for (int n = 14; n < 16; n++) mSel[n] = int'((mA >> (22 - 2*(n-14))) & 32'h3);
        end
      end
      mStat = (mStat & ~clr) | (inW & mMask);
    end
  end

  // ---------------- checking helpers ----------------
  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    chk("R6", {28'h0, routedIrq}, {28'h0, modelRoutes()});
    chk("R10", {31'h0, latchedIrq}, {31'h0, (mStat != 0)});
    if (mRdValid) chk(rdTag, rdData, mRd);
  endtask

  task automatic wr(int a, logic [31:0] d);
    wrEn = 1'b1; addr = 8'(a); wrData = d;
    cyc();
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rd(int a, logic [31:0] exp, string tag);
    rdTag = tag; rdEn = 1'b1; addr = 8'(a);
    cyc();
    rdEn = 1'b0;
    chk(tag, rdData, exp);
    rdTag = "R2";
  endtask

  task automatic doReset(logic mode);
    rstN = 1'b0; legacyMode = mode; reqIn = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    cyc();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    // R1: reset state in routed mode
    doReset(1'b0);
    chk("R1", {31'h0, latchedIrq}, 32'h0);
    rd('h08, 32'h0, "R1");
    rd('h0C, 32'h0, "R1");
    rd('h50, 32'h0, "R1");
    rd('h54, 32'h0, "R1");
    reqIn = 16'hFFFF;
    #0.5 chk("R1", {28'h0, routedIrq}, 32'h1);
    cyc();
    reqIn = '0;

    // R4: req0 -> output 3 (bits 27:26), req13 -> output 2 (bits 1:0)
    wr('h0C, 32'h0C00_0002);
    rd('h0C, 32'h0C00_0002, "R2");
    reqIn = 16'h0001; #0.5 chk("R4", {28'h0, routedIrq}, 32'h8); cyc();
    reqIn = 16'h2000; #0.5 chk("R4", {28'h0, routedIrq}, 32'h4); cyc();
    reqIn = 16'h1FFE; #0.5 chk("R4", {28'h0, routedIrq}, 32'h1); cyc();

    // R5: req14 -> 1 (bits 23:22), req15 -> 3 (bits 21:20)
    wr('h08, 32'h0070_0000);
    rd('h08, 32'h0070_0000, "R2");
    reqIn = 16'h4000; #0.5 chk("R5", {28'h0, routedIrq}, 32'h2); cyc();
    reqIn = 16'h8000; #0.5 chk("R5", {28'h0, routedIrq}, 32'h8); cyc();

    // R6: steer write takes effect after the edge; several patterns
    reqIn = 16'h0002;
    wr('h0C, 32'h0200_0000);             // req1 -> output 2
    chk("R6", {28'h0, routedIrq}, 32'h4);
    reqIn = 16'hC003; cyc();
    reqIn = 16'h0000; cyc();
    reqIn = 16'h5A5A; cyc();

    // R3: unmapped offsets
    rd('h10, 32'hFFFF_FFFF, "R3");
    rd('h00, 32'hFFFF_FFFF, "R3");
    rd('h5D, 32'hFFFF_FFFF, "R3");

    // R12 / R7: polarity no effect, input writes dropped, no latch in routed mode
    wr('h54, 32'hFFFF_FFFF);
    wr('h58, 32'hFFFF_FFFF);
    rd('h58, 32'hFFFF_FFFF, "R12");
    wr('h5C, 32'hFFFF_FFFF);
    rd('h5C, 32'h0, "R7");
    repeat (3) cyc();
    chk("R7", {31'h0, latchedIrq}, 32'h0);
    chk("R12", {28'h0, routedIrq}, {28'h0, modelRoutes()});
    reqIn = '0;

    // Legacy mode
    doReset(1'b1);
    reqIn = 16'h0010;
    rd('h5C, 32'h0000_0800, "R9");
    cyc();
    chk("R10", {31'h0, latchedIrq}, 32'h0);       // mask still zero
    chk("R8", {28'h0, routedIrq}, 32'h0);
    wr('h54, 32'h0000_0800);
    chk("R13", {31'h0, latchedIrq}, 32'h1);
    rd('h50, 32'h0000_0800, "R10");
    wr('h50, 32'h0000_0800);                      // request still active
    chk("R11", {31'h0, latchedIrq}, 32'h1);
    reqIn = '0;
    repeat (3) cyc();
    chk("R10", {31'h0, latchedIrq}, 32'h1);       // sticky
    rd('h5C, 32'h0, "R9");
    wr('h50, 32'h0000_0800);
    chk("R11", {31'h0, latchedIrq}, 32'h0);
    wr('h5C, 32'hFFFF_FFFF);
    reqIn = 16'h8000;
    rd('h5C, 32'h0000_0800, "R12");
    wr('h50, 32'hFFFF_FFFF);
    reqIn = '0;
    wr('h50, 32'hFFFF_FFFF);
    chk("R11", {31'h0, latchedIrq}, 32'h0);

    // R8: steer writes in legacy mode do not load the table
    wr('h0C, 32'hFFFF_FFFF);
    wr('h08, 32'hFFFF_FFFF);
    rd('h0C, 32'hFFFF_FFFF, "R8");
    reqIn = 16'h0001; cyc();
    chk("R8", {28'h0, routedIrq}, 32'h0);
    wr('h54, 32'h0);
    reqIn = '0;
    wr('h50, 32'hFFFF_FFFF);
    legacyMode = 1'b0;
    reqIn = 16'h0001;
    #0.5 chk("R8", {28'h0, routedIrq}, 32'h1);
    cyc();
    reqIn = '0;
    cyc();

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule